// File: doc/BRIEF.md
# SPI Byte Receiver with Capture

A receive-only serial peripheral. While chip select is held low, it takes one data bit from the controller on every rising edge of the serial clock. Bits arrive most-significant first. A separate edge counter runs on the same clock and detects the eighth rising edge. On the falling clock edge that follows, the assembled byte is copied into a holding register and a ready flag is raised.

Chip select never gates the clock. It acts as a synchronous enable: when it is high, every data flop reloads its own value through a hold path. Releasing chip select clears the counter and the ready flag, so the next assertion starts a fresh byte. Only one byte is taken per assertion. Clock edges beyond the eighth keep shifting data but cause no second capture.

Top module: `spi_byte_rx`

## Requirements
- R1: An active-low asynchronous reset clears the shift register, the held byte and the ready flag to zero.
- R2: While chip select is low, each rising serial clock edge shifts the data input into bit 0 and moves earlier bits up one place, so that after eight edges bit 7 holds the first bit sent and bit 0 the last.
- R3: While chip select is high, serial clock edges leave the shift register and the held byte unchanged.
- R4: After the eighth rising edge of an assertion, the held byte is unchanged until the next falling edge. At that falling edge, the held byte takes the shift register value and the ready flag goes high.
- R5: If chip select is released after fewer than eight rising edges, the held byte and the ready flag do not change.
- R6: The edge count saturates at eight. Further edges in the same assertion keep shifting but neither change the held byte nor lower the ready flag.
- R7: Releasing chip select drops the ready flag at once and clears the count, so a following assertion captures only after eight new rising edges.
- R8: A reset asserted in the middle of a transfer returns all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the controller |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the controller |
| shift_o | output | DATA_W | Live shift register contents |
| byte_o | output | DATA_W | Last captured byte |
| ready_o | output | 1 | High from capture until chip select is released |

## Verification
A table of byte values is sent, each as a full eight-edge transfer. The values include alternating patterns, all zeros, all ones and a single set bit at either end, which separate a correct most-significant-first order from a reversed or off-by-one shift. Between the eighth rising edge and the following falling edge, the held byte must still show its old value, which marks the exact capture edge. Further transfers cover a partial transfer followed by a full one, which tells a cleared counter from a leftover count. They also cover surplus edges, which tell a saturating counter from a wrapping one, clock activity while chip select is high, and a reset in the middle of a transfer.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  parameter int unsigned SPI_RX_DATA_W = 8;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic [DATA_W-1:0] shift_o
);
  logic [DATA_W-1:0] shift_q;

  // enable mux, clock stays ungated
  always_ff @(posedge sck_i or negedge rst_ni) begin
    if (!rst_ni)     shift_q <= '0;
    else if (!cs_ni) shift_q <= {shift_q[DATA_W-2:0], mosi_i};
    else             shift_q <= shift_q;
  end

  assign shift_o = shift_q;

  // R2
  shift_msb_first_chk: assert property (@(posedge sck_i) disable iff (!rst_ni || cs_ni)
    1'b1 |=> shift_q == {$past(shift_q[DATA_W-2:0]), $past(mosi_i)});
endmodule

// File: rtl/spi_rx_count.sv
module spi_rx_count #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = spi_rx_pkg::cnt_bits(DATA_W)
) (
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  output logic full_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DATA_W);

  logic [CNT_W-1:0] cnt_q;

  // chip select release clears the count asynchronously
  always_ff @(posedge sck_i or negedge rst_ni or posedge cs_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cs_ni)          cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == LIMIT);

  // R6
  cnt_saturate_chk: assert property (@(posedge sck_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
endmodule

// File: rtl/spi_rx_capture.sv
module spi_rx_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              full_i,
  input  logic [DATA_W-1:0] shift_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              ready_o
);
  logic [DATA_W-1:0] byte_q;
  logic              ready_q;

  always_ff @(negedge sck_i or negedge rst_ni) begin
    if (!rst_ni)                 byte_q <= '0;
    else if (full_i && !ready_q) byte_q <= shift_i;
  end

  always_ff @(negedge sck_i or negedge rst_ni or posedge cs_ni) begin
    if (!rst_ni)     ready_q <= 1'b0;
    else if (cs_ni)  ready_q <= 1'b0;
    else if (full_i) ready_q <= 1'b1;
  end

  assign byte_o  = byte_q;
  assign ready_o = ready_q;

  // R4
  ready_needs_full_chk: assert property (@(negedge sck_i) disable iff (!rst_ni || cs_ni)
    ready_q |-> full_i);

  // R6
  no_second_capture_chk: assert property (@(negedge sck_i) disable iff (!rst_ni || cs_ni)
    ready_q |=> $stable(byte_q));
endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx #(
  parameter int unsigned DATA_W = spi_rx_pkg::SPI_RX_DATA_W
) (
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic [DATA_W-1:0] shift_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              ready_o
);
  logic              full;
  logic [DATA_W-1:0] shift;

  spi_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .cs_ni  (cs_ni),
    .mosi_i (mosi_i),
    .shift_o(shift)
  );

  spi_rx_count #(.DATA_W(DATA_W)) u_count (
    .rst_ni(rst_ni),
    .sck_i (sck_i),
    .cs_ni (cs_ni),
    .full_o(full)
  );

  spi_rx_capture #(.DATA_W(DATA_W)) u_capture (
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .cs_ni  (cs_ni),
    .full_i (full),
    .shift_i(shift),
    .byte_o (byte_o),
    .ready_o(ready_o)
  );

  assign shift_o = shift;
endmodule

// File: tb/spi_byte_rx_tb.sv
module spi_byte_rx_tb;
  localparam int CLK_PERIOD = 20;
  localparam int Q = CLK_PERIOD / 4;
  localparam int NVEC = 7;
  localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h5A, 8'h00, 8'hFF, 8'h80, 8'h01, 8'h3C};

  logic clk = 1'b0;
  logic rst_ni = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [7:0] shift_o, byte_o;
  logic ready_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_rx u_dut (
    .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .shift_o(shift_o), .byte_o(byte_o), .ready_o(ready_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rise(input logic b);
    mosi = b; #Q; sck = 1'b1; #Q;
  endtask

  task automatic fall();
    #Q; sck = 1'b0; #Q;
  endtask

  task automatic send(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      rise(v[7-i]);
      fall();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] last;
    #Q;
    // R1 reset state
    chk("R1 shift", 32'(shift_o), 0);
    chk("R1 byte", 32'(byte_o), 0);
    chk("R1 ready", 32'(ready_o), 0);
    #CLK_PERIOD; rst_ni = 1'b1; #CLK_PERIOD;

    last = 8'h00;
    for (int k = 0; k < NVEC; k++) begin
      cs_n = 1'b0; #CLK_PERIOD;
      send(VEC[k], 7);
      rise(VEC[k][0]);
      chk("R2 shift", 32'(shift_o), 32'(VEC[k]));
      chk("R4 before falling edge byte", 32'(byte_o), 32'(last));
      chk("R4 before falling edge ready", 32'(ready_o), 0);
      fall();
      chk("R4 byte", 32'(byte_o), 32'(VEC[k]));
      chk("R4 ready", 32'(ready_o), 1);
      cs_n = 1'b1; #Q;
      chk("R7 ready drop", 32'(ready_o), 0);
      #CLK_PERIOD;
      last = VEC[k];
    end

    // R3 clock activity while deselected
    send(8'hFF, 8);
    chk("R3 shift", 32'(shift_o), 32'(last));
    chk("R3 byte", 32'(byte_o), 32'(last));

    // R5 partial transfer
    cs_n = 1'b0; #CLK_PERIOD;
    send(8'hFF, 5);
    cs_n = 1'b1; #CLK_PERIOD;
    chk("R5 byte", 32'(byte_o), 32'(last));
    chk("R5 ready", 32'(ready_o), 0);

    // R7 fresh count after partial
    cs_n = 1'b0; #CLK_PERIOD;
    send(8'h96, 7);
    chk("R7 no early capture byte", 32'(byte_o), 32'(last));
    chk("R7 no early capture ready", 32'(ready_o), 0);
    rise(1'b0); fall();
    chk("R7 byte", 32'(byte_o), 32'h96);
    chk("R7 ready", 32'(ready_o), 1);

    // R6 surplus edges
    send(8'hFF, 4);
    chk("R6 shift continues", 32'(shift_o), 32'h6F);
    chk("R6 byte held", 32'(byte_o), 32'h96);
    chk("R6 ready held", 32'(ready_o), 1);
    cs_n = 1'b1; #CLK_PERIOD;

    // R8 reset mid-transfer
    cs_n = 1'b0; #CLK_PERIOD;
    send(8'hE0, 3);
    rst_ni = 1'b0; #Q;
    chk("R8 shift", 32'(shift_o), 0);
    chk("R8 byte", 32'(byte_o), 0);
    chk("R8 ready", 32'(ready_o), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule